// File: doc/BRIEF.md
# UART Task-Event Register Controller

This block is the register-side controller of a byte-level UART. Software drives it through a 32-bit word-addressed register bus. Actions are triggered by writing to task registers, and the controller reports conditions through sticky event registers. It exchanges whole bytes with an abstract receiver and transmitter. Serial bit timing, baud generation, pin routing and flow control live outside the block.

Incoming bytes enter through a valid/ready handshake and land in a small circular FIFO. Software drains the FIFO by reading the receive data register. The transmit side holds one byte and presents it with a request level until the transmitter returns a done pulse.

There are four events: receive ready, transmit done, fault and receive timeout. Each event can drive the single level interrupt through its own enable bit. The enable register has three access addresses: replace, set-bits and clear-bits.

Top module: `uart_evt_ctrl`

## Requirements
- R1: After reset, the pin-select words at offsets 13, 14, 15 and 16 read 0xFFFFFFFF and the rate word at offset 19 reads 0x04000000. Every other register reads 0, and `irq`, `rx_ready` and `tx_req` are low.
- R2: Bit 0 of the on/off word at offset 12 enables the block. While that bit is 0, a write to any other offset changes nothing.
- R3: The interrupt mask behaves as follows. Offset 8 replaces it with the written word, offset 9 ORs the written word into it, and offset 10 clears each bit that is 1 in the written word.
- R4: `irq` is high exactly when, for some event n, the event word is nonzero and mask bit n is 1. The events are: receive ready (bit 0, offset 4), transmit done (bit 1, offset 5), fault (bit 2, offset 6) and receive timeout (bit 3, offset 7). `irq` follows a register write from the next cycle.
- R5: Software may write any value into the event words at offsets 4 to 7, and writing 0 clears the event. If hardware sets an event in the same cycle, the hardware set wins and the word becomes 1.
- R6: In the fault source word at offset 11, writing a 1 to a bit clears that bit, and bits written as 0 are kept. A `rx_break` pulse sets bits 1:0 of the fault source word and sets the fault event.
- R7: The task words are 0 (start receive), 1 (stop receive), 2 (start transmit) and 3 (stop transmit). A task acts only when written with bit 0 = 1. Stopping receive also sets the receive timeout event.
- R8: A byte is accepted (`rx_valid` and `rx_ready` both high) only while receive is started and the 6-entry FIFO is not full. `rx_ready` is low otherwise. Each accepted byte sets the receive ready event.
- R9: A read of offset 17 returns the FIFO head byte in bits 7:0. The head advances only when receive is started and the FIFO is not empty. If bytes remain after the pop, the receive ready event is set.
- R10: A write to offset 18 loads a byte only when transmit is started and no byte is pending. The loaded byte is presented on `tx_byte` with `tx_req` high until a `tx_done` pulse, which clears `tx_req` and sets the transmit done event.
- R11: Read data appears on `bus_rdata` in the cycle after the read request. Bytes leave the FIFO in arrival order across any number of pointer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt |
| rx_byte | input | BYTE_W | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | Controller can take a byte |
| rx_break | input | 1 | Line break pulse |
| tx_byte | output | BYTE_W | Byte to send |
| tx_req | output | 1 | Byte pending for transmitter |
| tx_done | input | 1 | Transmitter finished the byte |

## Verification
The bench builds the controller with its defaults: a 6-entry FIFO, 8-bit bytes and a 5-bit word offset. Because the depth is not a power of two, the head and tail wrap logic is exercised through its modulo path. Random push/read traffic runs against a bench queue, so the head wraps many times and the FIFO reaches full often. The full case lets the bench confirm that a seventh byte is refused.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;
  localparam int unsigned BUS_W = 32;

  // word offsets
  localparam int unsigned OFS_RX_GO    = 0;
  localparam int unsigned OFS_RX_HALT  = 1;
  localparam int unsigned OFS_TX_GO    = 2;
  localparam int unsigned OFS_TX_HALT  = 3;
  localparam int unsigned OFS_EV_BASE  = 4;
  localparam int unsigned OFS_MASK     = 8;
  localparam int unsigned OFS_MASK_SET = 9;
  localparam int unsigned OFS_MASK_CLR = 10;
  localparam int unsigned OFS_FAULT    = 11;
  localparam int unsigned OFS_ON       = 12;
  localparam int unsigned OFS_PIN_BASE = 13;
  localparam int unsigned OFS_RX_DATA  = 17;
  localparam int unsigned OFS_TX_DATA  = 18;
  localparam int unsigned OFS_RATE     = 19;

  // event indices (also mask bit positions)
  localparam int unsigned EV_RXRDY = 0;
  localparam int unsigned EV_TXFIN = 1;
  localparam int unsigned EV_FAULT = 2;
  localparam int unsigned EV_RXTO  = 3;
  localparam int unsigned NUM_EV   = 4;
  localparam int unsigned NUM_PIN  = 4;

  localparam logic [BUS_W-1:0] PIN_RST  = '1;
  localparam logic [BUS_W-1:0] RATE_RST = 32'h0400_0000;
  localparam logic [BUS_W-1:0] BRK_BITS = 32'h0000_0003;
endpackage

// File: rtl/uart_evt_rxfifo.sv
module uart_evt_rxfifo #(
  parameter int unsigned DEPTH  = 6,
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              pop,
  output logic [BYTE_W-1:0] head_data,
  output logic [CW-1:0]     count,
  output logic              full,
  output logic              empty
);
  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     head_q;
  logic [CW-1:0]     count_q;
  logic [PW:0]       tail_sum;
  logic [PW-1:0]     tail;
  logic [PW-1:0]     head_nx;

  assign tail_sum = {1'b0, head_q} + (PW+1)'(count_q);
  assign tail = (tail_sum >= (PW+1)'(DEPTH)) ? PW'(tail_sum - (PW+1)'(DEPTH))
                                              : PW'(tail_sum);
  assign head_nx = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + PW'(1);

  // storage without reset so it maps to RAM
  always_ff @(posedge clk) begin
    if (push) mem[tail] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q  <= '0;
      count_q <= '0;
    end else begin
      if (pop) head_q <= head_nx;
      case ({push, pop})
        2'b10:   count_q <= count_q + CW'(1);
        2'b01:   count_q <= count_q - CW'(1);
        default: count_q <= count_q;
      endcase
    end
  end

  assign head_data = mem[head_q];
  assign count     = count_q;
  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
endmodule

// File: rtl/uart_evt_txpath.sv
module uart_evt_txpath #(
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_data,
  input  logic              done_in,
  output logic              busy,
  output logic [BYTE_W-1:0] byte_out,
  output logic              finished
);
  logic              busy_q;
  logic [BYTE_W-1:0] byte_q;

  assign finished = done_in & busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      byte_q <= '0;
    end else if (load && !busy_q) begin
      busy_q <= 1'b1;
      byte_q <= load_data;
    end else if (finished) begin
      busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign byte_out = byte_q;
endmodule

// File: rtl/uart_evt_irq.sv
module uart_evt_irq #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] ev_nz,
  input  logic [N-1:0] mask,
  output logic         irq
);
  logic [N-1:0] term;

  for (genvar g = 0; g < N; g++) begin : g_term
    assign term[g] = ev_nz[g] & mask[g];
  end

  assign irq = |term;
endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
  import uart_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DEPTH  = 6,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic              rx_break,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_req,
  input  logic              tx_done
);
  function automatic logic hit(input int unsigned ofs);
    return bus_addr == ADDR_W'(ofs);
  endfunction

  logic [BUS_W-1:0] on_q, mask_q, fault_q, rate_q, rdata_q, rd_mux;
  logic [BUS_W-1:0] ev_q  [NUM_EV];
  logic [BUS_W-1:0] pin_q [NUM_PIN];
  logic [NUM_EV-1:0] ev_set, ev_wr, ev_nz;
  logic rx_on_q, tx_on_q;
  logic wr_req, rd_req, wr_ok;
  logic go_rx, halt_rx, go_tx, halt_tx;
  logic rx_push, rx_pop, tx_load, tx_fin, tx_busy;
  logic [BYTE_W-1:0] head_byte;
  logic [CW-1:0]     fifo_count;
  logic fifo_full, fifo_empty;

  assign wr_req = bus_sel & bus_we;
  assign rd_req = bus_sel & ~bus_we;
  assign wr_ok  = wr_req & (on_q[0] | hit(OFS_ON));

  assign go_rx   = wr_ok & hit(OFS_RX_GO)   & bus_wdata[0];
  assign halt_rx = wr_ok & hit(OFS_RX_HALT) & bus_wdata[0];
  assign go_tx   = wr_ok & hit(OFS_TX_GO)   & bus_wdata[0];
  assign halt_tx = wr_ok & hit(OFS_TX_HALT) & bus_wdata[0];

  assign rx_ready = rx_on_q & ~fifo_full;
  assign rx_push  = rx_valid & rx_ready;
  assign rx_pop   = rd_req & hit(OFS_RX_DATA) & rx_on_q & ~fifo_empty;
  assign tx_load  = wr_ok & hit(OFS_TX_DATA) & tx_on_q & ~tx_busy;

  uart_evt_rxfifo #(.DEPTH(DEPTH), .BYTE_W(BYTE_W)) u_rxfifo (
    .clk(clk), .rst(rst), .push(rx_push), .push_data(rx_byte),
    .pop(rx_pop), .head_data(head_byte), .count(fifo_count),
    .full(fifo_full), .empty(fifo_empty)
  );

  uart_evt_txpath #(.BYTE_W(BYTE_W)) u_txpath (
    .clk(clk), .rst(rst), .load(tx_load), .load_data(bus_wdata[BYTE_W-1:0]),
    .done_in(tx_done), .busy(tx_busy), .byte_out(tx_byte), .finished(tx_fin)
  );

  assign tx_req = tx_busy;

  // hardware event sources
  always_comb begin
    ev_set           = '0;
    ev_set[EV_RXRDY] = rx_push | (rx_pop & (fifo_count > CW'(1)));
    ev_set[EV_TXFIN] = tx_fin;
    ev_set[EV_FAULT] = rx_break;
    ev_set[EV_RXTO]  = halt_rx;
  end

  for (genvar g = 0; g < NUM_EV; g++) begin : g_ev
    assign ev_wr[g] = wr_ok & hit(OFS_EV_BASE + g);
    always_ff @(posedge clk) begin
      if (rst)            ev_q[g] <= '0;
      else if (ev_set[g]) ev_q[g] <= 32'd1;
      else if (ev_wr[g])  ev_q[g] <= bus_wdata;
    end
    assign ev_nz[g] = |ev_q[g];
  end

  for (genvar g = 0; g < NUM_PIN; g++) begin : g_pin
    always_ff @(posedge clk) begin
      if (rst)                                pin_q[g] <= PIN_RST;
      else if (wr_ok && hit(OFS_PIN_BASE + g)) pin_q[g] <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q    <= '0;
      mask_q  <= '0;
      fault_q <= '0;
      rate_q  <= RATE_RST;
      rx_on_q <= 1'b0;
      tx_on_q <= 1'b0;
    end else begin
      if (wr_ok && hit(OFS_ON))   on_q   <= bus_wdata;
      if (wr_ok && hit(OFS_RATE)) rate_q <= bus_wdata;

      if (wr_ok && hit(OFS_MASK))          mask_q <= bus_wdata;
      else if (wr_ok && hit(OFS_MASK_SET)) mask_q <= mask_q | bus_wdata;
      else if (wr_ok && hit(OFS_MASK_CLR)) mask_q <= mask_q & ~bus_wdata;

      fault_q <= ((wr_ok && hit(OFS_FAULT)) ? (fault_q & ~bus_wdata) : fault_q)
               | (rx_break ? BRK_BITS : '0);

      if (go_rx)        rx_on_q <= 1'b1;
      else if (halt_rx) rx_on_q <= 1'b0;
      if (go_tx)        tx_on_q <= 1'b1;
      else if (halt_tx) tx_on_q <= 1'b0;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit(OFS_MASK))    rd_mux = mask_q;
    if (hit(OFS_FAULT))   rd_mux = fault_q;
    if (hit(OFS_ON))      rd_mux = on_q;
    if (hit(OFS_RATE))    rd_mux = rate_q;
    if (hit(OFS_RX_DATA)) rd_mux = BUS_W'(head_byte);
    if (hit(OFS_TX_DATA)) rd_mux = BUS_W'(tx_byte);
    for (int i = 0; i < NUM_EV; i++)
      if (hit(OFS_EV_BASE + i)) rd_mux = ev_q[i];
    for (int i = 0; i < NUM_PIN; i++)
      if (hit(OFS_PIN_BASE + i)) rd_mux = pin_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         rdata_q <= '0;
    else if (rd_req) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  uart_evt_irq #(.N(NUM_EV)) u_irq (
    .ev_nz(ev_nz), .mask(mask_q[NUM_EV-1:0]), .irq(irq)
  );
endmodule

// File: rtl/uart_evt_chk.sv
module uart_evt_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned DEPTH  = 6,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wbit0,
  input logic              irq,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [BYTE_W-1:0] tx_byte,
  input logic              tx_req,
  input logic              tx_done,
  input logic              en,
  input logic [3:0]        mask,
  input logic [3:0]        ev_nz,
  input logic [CW-1:0]     count
);
  assert_tx_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_req && !tx_done) |=> (tx_req && $stable(tx_byte)));

  assert_tx_done_event_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_req && tx_done) |=> (!tx_req && ev_nz[1]));

  assert_rx_accept_event_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_ready) |=> ev_nz[0]);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));

  assert_full_refuses_R8: assert property (@(posedge clk) disable iff (rst)
    (count == CW'(DEPTH)) |-> !rx_ready);

  assert_off_mask_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && !en && bus_addr != ADDR_W'(12)) |=> $stable(mask));

  assert_halt_rx_R7: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && en && bus_addr == ADDR_W'(1) && wbit0)
      |=> (!rx_ready && ev_nz[3]));

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    (mask == 4'd0) |-> !irq);
endmodule

bind uart_evt_ctrl uart_evt_chk #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
  .wbit0(bus_wdata[0]), .irq(irq), .rx_valid(rx_valid), .rx_ready(rx_ready),
  .tx_byte(tx_byte), .tx_req(tx_req), .tx_done(tx_done), .en(on_q[0]),
  .mask(mask_q[3:0]), .ev_nz(ev_nz), .count(fifo_count)
);

// File: tb/tb_uart_evt_ctrl.sv
module tb_uart_evt_ctrl;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned DEPTH  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, rx_ready, tx_req;
  logic [BYTE_W-1:0] rx_byte = '0;
  logic rx_valid = 1'b0, rx_break = 1'b0, tx_done = 1'b0;
  logic [BYTE_W-1:0] tx_byte;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [$];

  always #5 clk = ~clk;

  uart_evt_ctrl #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_break(rx_break),
    .tx_byte(tx_byte), .tx_req(tx_req), .tx_done(tx_done)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input int unsigned a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input int unsigned a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = ADDR_W'(a);
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push(input logic [7:0] b, output logic ok);
    @(negedge clk);
    rx_valid = 1'b1; rx_byte = b;
    ok = rx_ready;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  function automatic logic exp_accept(input int occ);
    return occ < int'(DEPTH);
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [31:0] d;
    logic ok;
    int unsigned r;
    r = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int i = 13; i <= 16; i++) begin rd(i, d); chk("R1 pin", d, 32'hFFFF_FFFF); end
    rd(19, d); chk("R1 rate", d, 32'h0400_0000);
    rd(12, d); chk("R1 on", d, 0);
    rd(8, d);  chk("R1 mask", d, 0);
    rd(4, d);  chk("R1 event", d, 0);
    chk("R1 outs", {29'd0, irq, rx_ready, tx_req}, 0);

    // R2 writes ignored while off
    wr(8, 32'hF); rd(8, d); chk("R2 mask", d, 0);
    wr(0, 1); chk("R2 rx_ready", rx_ready, 0);
    wr(12, 1); rd(12, d); chk("R2 on", d, 1);

    // R3 mask access modes
    wr(8, 32'h5);  rd(8, d); chk("R3 replace", d, 32'h5);
    wr(9, 32'h2);  rd(8, d); chk("R3 set", d, 32'h7);
    wr(10, 32'h5); rd(8, d); chk("R3 clear", d, 32'h2);

    // R6 break
    pulse(rx_break);
    rd(11, d); chk("R6 src", d, 32'h3);
    rd(6, d);  chk("R6 event", d, 1);
    chk("R4 masked off", irq, 0);
    wr(9, 32'h4); chk("R4 irq on", irq, 1);
    wr(11, 32'h1); rd(11, d); chk("R6 w1c", d, 32'h2);
    wr(6, 0); chk("R5 sw clear", irq, 0);
    wr(8, 0);

    // R7 / R8 receive start and fill
    push(8'h99, ok); chk("R8 stopped refuse", ok, 0);
    wr(0, 0); chk("R7 bit0 zero", rx_ready, 0);
    wr(0, 1); chk("R7 start rx", rx_ready, 1);
    for (int i = 0; i < 7; i++) begin
      push(8'h11 + 8'(i), ok);
      chk("R8 accept", ok, exp_accept(i));
    end
    chk("R8 full ready", rx_ready, 0);
    rd(4, d); chk("R8 event", d, 1);

    // R9 pops
    wr(4, 0);
    rd(17, d); chk("R9 head", d, 32'h11);
    rd(4, d);  chk("R9 reraise", d, 1);
    for (int i = 1; i < 5; i++) begin rd(17, d); chk("R11 order", d, 32'h11 + i); end
    wr(4, 0);
    rd(17, d); chk("R9 last", d, 32'h16);
    rd(4, d);  chk("R9 no reraise", d, 0);

    // R7 stop rx, R9 no pop while stopped
    push(8'hA1, ok); push(8'hA2, ok);
    wr(1, 1);
    rd(7, d);  chk("R7 timeout", d, 1);
    chk("R7 stopped", rx_ready, 0);
    rd(17, d); chk("R9 stopped read", d, 32'hA1);
    rd(17, d); chk("R9 no pop", d, 32'hA1);
    wr(0, 1);
    rd(17, d); chk("R11 after restart", d, 32'hA1);
    rd(17, d); chk("R11 after restart", d, 32'hA2);

    // R5 hardware set beats software clear
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = ADDR_W'(4); bus_wdata = 0;
    rx_valid = 1'b1; rx_byte = 8'h5A;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; rx_valid = 1'b0;
    rd(4, d); chk("R5 hw wins", d, 1);
    rd(17, d); chk("R11 collision byte", d, 32'h5A);

    // R10 transmit
    wr(18, 32'h55); chk("R10 not started", tx_req, 0);
    wr(2, 1);
    wr(18, 32'hA5);
    chk("R10 req", tx_req, 1); chk("R10 byte", tx_byte, 8'hA5);
    wr(18, 32'h3C); chk("R10 pending hold", tx_byte, 8'hA5);
    wr(8, 32'h2); chk("R4 no tx event", irq, 0);
    pulse(tx_done);
    chk("R10 req clear", tx_req, 0);
    rd(5, d); chk("R10 event", d, 1);
    chk("R4 tx irq", irq, 1);
    wr(3, 1); wr(18, 32'h77); chk("R7 stop tx", tx_req, 0);
    wr(8, 0);

    // R11 random traffic against queue model
    for (int it = 0; it < 600; it++) begin
      r = $urandom % 3;
      if (r == 0) begin
        logic [7:0] b;
        b = 8'($urandom);
        push(b, ok);
        chk("R8 random accept", ok, exp_accept(model.size()));
        if (ok) model.push_back(b);
      end else if (r == 1 && model.size() > 0) begin
        logic [7:0] e;
        e = model.pop_front();
        rd(17, d);
        chk("R11 random order", d, {24'd0, e});
      end else begin
        @(negedge clk);
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule